// File: doc/BRIEF.md
# Interleaved Multichannel FIR Filter

This block is a single-rate FIR filter shared by several data channels. The channels take turns on one input stream in a fixed round-robin order. Each channel keeps its own history of past samples, so the filter state of one channel never leaks into another. Each accepted sample yields one filtered result on the output stream one clock edge later. That result is tagged with its channel index on `m_user`, and a last-of-vector marker is generated on `m_last`.

All coefficient sets are fixed at elaboration in a single packed parameter, with the sets placed one after another. A side configuration stream carries a set-select value. That value is taken only when a channel-0 sample is accepted, so a whole vector of channels is always filtered with the same set. In vector mode, input `s_last` must mark channel NCH-1. A mismatch is flagged and the channel counter is realigned. In packet mode, `s_last` is passed through unchanged, and it arms the next configuration update. A clock enable freezes the block. An active-low reset enters through an internal register and overrides the enable.

Top module: `mcfir`

## Requirements
- R1: Each accepted sample (`s_valid` high while `aclken` high) is given a channel index in the order 0, 1, …, NCH-1, 0, …. One edge later, `m_valid` is high and `m_user` holds that index. `m_user` is the index in binary, and its width is the bits needed for NCH-1 (at least 1).
- R2: `m_data` equals the sum over i = 0..NTAPS-1 of c[s][i]·x[n-i]. Here x[n] is the sample just taken, and x[n-i] are earlier samples of the same channel only, taken as zero before the first one. The sum is formed at full width AW = DW+CW+clog2(NTAPS) and then truncated by removing its AW-OW lowest bits, which gives an arithmetic floor.
- R3: Coefficient c[s][i] is the signed CW-bit field at `COEF[(s·NTAPS+i)·CW +: CW]`, so set 0 occupies the lowest bits. Set 0 is active after reset.
- R4: In vector mode, `cfg_ready` is high exactly in a cycle that accepts a channel-0 sample. If `cfg_valid` is high then, `cfg_sel` takes effect for that sample and all later samples. At any other time the selection is not taken.
- R5: A taken `cfg_sel` value of NSETS or more leaves the active set unchanged.
- R6: In vector mode, `m_last` is high exactly with the result of channel NCH-1.
- R7: In vector mode, `frame_err` is raised together with the result of a sample for which `s_last` disagrees with "channel is NCH-1". It clears on the next accepted sample. After any accepted sample with `s_last` high, the next sample is channel 0.
- R8: In packet mode, `s_last` is copied to `m_last` with the data latency and `frame_err` stays low. `cfg_ready` is high only on a channel-0 sample, and only if a transfer with `s_last` high has been accepted since reset or since the last taken configuration.
- R9: While `aclken` is low, no output and no internal state changes, and `cfg_ready` is low.
- R10: With `aclken` high and `s_valid` low, `m_valid` is low after the edge and no filter state changes.
- R11: Holding `aresetn` low for two edges, whatever the state of `aclken`, clears `m_valid`, `m_data`, `m_user`, `m_last` and `frame_err`. It also clears every history, the channel counter, the active set and the packet arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| aresetn | input | 1 | Active-low reset, registered internally |
| aclken | input | 1 | Clock enable, active high |
| s_valid | input | 1 | Input sample valid |
| s_data | input | DW | Signed input sample |
| s_last | input | 1 | Input end-of-vector / packet marker |
| cfg_valid | input | 1 | Configuration value present |
| cfg_sel | input | max(1,clog2(NSETS)) | Requested coefficient set |
| cfg_ready | output | 1 | Configuration taken this cycle when valid |
| m_valid | output | 1 | Output result valid |
| m_data | output | OW | Signed truncated filter result |
| m_user | output | max(1,clog2(NCH)) | Channel index of the result |
| m_last | output | 1 | Output end-of-vector / packet marker |
| frame_err | output | 1 | Input framing disagreed with the channel counter |

## Verification
A wrong channel counter shows on `m_user` at the very next result. It also corrupts `m_data` from then on, because the wrong history is read and shifted. A history or coefficient fault shows as a wrong `m_data` value on the first sample that reaches the bad entry. That happens within NTAPS samples of the same channel. A set register that changes at the wrong time shows on the data of the first sample of the vector in which it changed, and `cfg_ready` shows the timing fault in the same cycle.

// File: rtl/mcfir_pkg.sv
package mcfir_pkg;

  typedef enum logic {
    SYNC_VECTOR = 1'b0,
    SYNC_PACKET = 1'b1
  } sync_mode_e;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mcfir_chan_seq.sv
module mcfir_chan_seq
  import mcfir_pkg::*;
#(
  parameter int         NCH  = 3,
  parameter sync_mode_e SYNC = SYNC_VECTOR,
  parameter int         CHW  = 2
) (
  input  logic           clk,
  input  logic           rst_q,
  input  logic           ce,
  input  logic           xfer,
  input  logic           s_last,
  output logic [CHW-1:0] ch_q,
  output logic           last_ch,
  output logic           mismatch
);

  logic [CHW-1:0] ch_d;

  assign last_ch  = (ch_q == CHW'(NCH - 1));
  assign mismatch = (SYNC == SYNC_VECTOR) && xfer && (s_last != last_ch);

  always_comb begin
    ch_d = ch_q;
    if (xfer) begin
      if (((SYNC == SYNC_VECTOR) && s_last) || last_ch) ch_d = '0;
      else                                              ch_d = ch_q + CHW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_q)  ch_q <= '0;
    else if (ce) ch_q <= ch_d;
  end

  assert_chan_range_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (int'(ch_q) < NCH));

  if (SYNC == SYNC_VECTOR) begin : g_vec_chk
    assert_resync_R7: assert property (@(posedge clk) disable iff (!rst_q)
      (xfer && s_last) |=> (ch_q == '0));
  end

endmodule

// File: rtl/mcfir_cfg_sync.sv
module mcfir_cfg_sync
  import mcfir_pkg::*;
#(
  parameter int         NSETS = 3,
  parameter sync_mode_e SYNC  = SYNC_VECTOR,
  parameter int         SELW  = 2
) (
  input  logic            clk,
  input  logic            rst_q,
  input  logic            ce,
  input  logic            xfer,
  input  logic            vec_start,
  input  logic            s_last,
  input  logic            cfg_valid,
  input  logic [SELW-1:0] cfg_sel,
  output logic            cfg_ready,
  output logic [SELW-1:0] set_cur
);

  logic            armed_q, armed_d;
  logic [SELW-1:0] set_q;
  logic            take;

  assign take      = vec_start && ((SYNC == SYNC_VECTOR) || armed_q);
  assign cfg_ready = take;

  if (NSETS > 1) begin : g_multi
    always_comb begin
      set_cur = set_q;
      if (take && cfg_valid && (int'(cfg_sel) < NSETS)) set_cur = cfg_sel;
    end
  end else begin : g_single
    assign set_cur = '0;
  end

  always_comb begin
    armed_d = armed_q;
    if (xfer && s_last)         armed_d = 1'b1;
    else if (take && cfg_valid) armed_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_q) begin
      set_q   <= '0;
      armed_q <= 1'b0;
    end else if (ce) begin
      set_q   <= set_cur;
      armed_q <= armed_d;
    end
  end

  assert_set_change_at_start_R4: assert property (@(posedge clk) disable iff (!rst_q)
    !$stable(set_q) |-> $past(cfg_ready && cfg_valid && ce));

endmodule

// File: rtl/mcfir_taps.sv
module mcfir_taps #(
  parameter int NCH   = 3,
  parameter int NTAPS = 4,
  parameter int DW    = 8,
  parameter int CHW   = 2
) (
  input  logic                       clk,
  input  logic                       rst_q,
  input  logic                       ce,
  input  logic                       xfer,
  input  logic [CHW-1:0]             ch,
  input  logic [DW-1:0]              din,
  output logic [NTAPS-1:0][DW-1:0]   taps
);

  localparam int LW = (NTAPS - 1) * DW;

  logic [NTAPS-2:0][DW-1:0] line_q [NCH];
  logic [NTAPS-2:0][DW-1:0] line_d [NCH];

  always_comb begin
    line_d = line_q;
    for (int c = 0; c < NCH; c++) begin
      if (xfer && (ch == CHW'(c))) line_d[c] = LW'({line_q[c], din});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_q)  line_q <= '{default: '0};
    else if (ce) line_q <= line_d;
  end

  assign taps = {line_q[ch], din};

endmodule

// File: rtl/mcfir_mac.sv
module mcfir_mac #(
  parameter int                          NTAPS = 4,
  parameter int                          NSETS = 3,
  parameter int                          DW    = 8,
  parameter int                          CW    = 8,
  parameter int                          SELW  = 2,
  parameter int                          AW    = 18,
  parameter logic [NSETS*NTAPS*CW-1:0]   COEF  = '0
) (
  input  logic [NTAPS-1:0][DW-1:0] taps,
  input  logic [SELW-1:0]          set,
  output logic signed [AW-1:0]     acc
);

  logic signed [DW+CW-1:0] prod [NTAPS];

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    logic signed [CW-1:0] k;
    assign k       = COEF[(int'(set) * NTAPS + i) * CW +: CW];
    assign prod[i] = $signed(taps[i]) * k;
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NTAPS; i++) acc = acc + AW'(prod[i]);
  end

endmodule

// File: rtl/mcfir.sv
module mcfir
  import mcfir_pkg::*;
#(
  parameter int         NCH   = 3,
  parameter int         NTAPS = 4,
  parameter int         NSETS = 3,
  parameter int         DW    = 8,
  parameter int         CW    = 8,
  parameter int         OW    = 16,
  parameter sync_mode_e SYNC  = SYNC_VECTOR,
  parameter logic [NSETS*NTAPS*CW-1:0] COEF = 96'h01F80007_02FD05FF_04030201,
  localparam int        CHW   = idx_w(NCH),
  localparam int        SELW  = idx_w(NSETS)
) (
  input  logic            clk,
  input  logic            aresetn,
  input  logic            aclken,
  input  logic            s_valid,
  input  logic [DW-1:0]   s_data,
  input  logic            s_last,
  input  logic            cfg_valid,
  input  logic [SELW-1:0] cfg_sel,
  output logic            cfg_ready,
  output logic            m_valid,
  output logic [OW-1:0]   m_data,
  output logic [CHW-1:0]  m_user,
  output logic            m_last,
  output logic            frame_err
);

  localparam int AW = DW + CW + $clog2(NTAPS);

  logic                     rst_q;
  logic                     xfer, vec_start;
  logic [CHW-1:0]           ch_q;
  logic                     last_ch, mismatch;
  logic [SELW-1:0]          set_cur;
  logic [NTAPS-1:0][DW-1:0] taps;
  logic signed [AW-1:0]     acc;

  logic                     valid_d, last_d, err_d;
  logic [OW-1:0]            data_d;
  logic [CHW-1:0]           user_d;

  always_ff @(posedge clk or negedge aresetn) begin
    if (!aresetn) rst_q <= 1'b0;
    else          rst_q <= 1'b1;
  end

  assign xfer      = rst_q && aclken && s_valid;
  assign vec_start = xfer && (ch_q == '0);

  mcfir_chan_seq #(.NCH(NCH), .SYNC(SYNC), .CHW(CHW)) u_seq (
    .clk(clk), .rst_q(rst_q), .ce(aclken), .xfer(xfer), .s_last(s_last),
    .ch_q(ch_q), .last_ch(last_ch), .mismatch(mismatch)
  );

  mcfir_cfg_sync #(.NSETS(NSETS), .SYNC(SYNC), .SELW(SELW)) u_cfg (
    .clk(clk), .rst_q(rst_q), .ce(aclken), .xfer(xfer), .vec_start(vec_start),
    .s_last(s_last), .cfg_valid(cfg_valid), .cfg_sel(cfg_sel),
    .cfg_ready(cfg_ready), .set_cur(set_cur)
  );

  mcfir_taps #(.NCH(NCH), .NTAPS(NTAPS), .DW(DW), .CHW(CHW)) u_taps (
    .clk(clk), .rst_q(rst_q), .ce(aclken), .xfer(xfer), .ch(ch_q),
    .din(s_data), .taps(taps)
  );

  mcfir_mac #(.NTAPS(NTAPS), .NSETS(NSETS), .DW(DW), .CW(CW), .SELW(SELW),
              .AW(AW), .COEF(COEF)) u_mac (
    .taps(taps), .set(set_cur), .acc(acc)
  );

  always_comb begin
    valid_d = xfer;
    data_d  = m_data;
    user_d  = m_user;
    last_d  = m_last;
    err_d   = mismatch;
    if (xfer) begin
      data_d = OW'(acc >>> (AW - OW));
      user_d = ch_q;
      last_d = (SYNC == SYNC_PACKET) ? s_last : last_ch;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_q) begin
      m_valid   <= 1'b0;
      m_data    <= '0;
      m_user    <= '0;
      m_last    <= 1'b0;
      frame_err <= 1'b0;
    end else if (aclken) begin
      m_valid   <= valid_d;
      m_data    <= data_d;
      m_user    <= user_d;
      m_last    <= last_d;
      frame_err <= err_d;
    end
  end

  assert_reset_clears_R11: assert property (@(posedge clk)
    !rst_q |=> (!m_valid && !frame_err && !m_last));

  assert_err_with_data_R7: assert property (@(posedge clk) disable iff (!rst_q)
    frame_err |-> m_valid);

  assert_user_range_R1: assert property (@(posedge clk) disable iff (!rst_q)
    m_valid |-> (int'(m_user) < NCH));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_q)
    !aclken |=> ($stable(m_data) && $stable(m_valid) && $stable(m_user)));

endmodule

// File: tb/mcfir_test.sv
`timescale 1ns/1ps
module mcfir_test;

  logic       clk = 1'b0;
  logic       aresetn, aclken, s_valid, s_last, cfg_valid;
  logic [7:0] s_data;
  logic [1:0] cfg_sel;

  logic        cfg_ready, m_valid, m_last, frame_err;
  logic [15:0] m_data;
  logic [1:0]  m_user;
  logic        p_cfg_ready, p_valid, p_last, p_err;
  logic [15:0] p_data;
  logic [1:0]  p_user;

  int n_chk = 0, n_fail = 0;
  int C [3][4] = '{'{1, 2, 3, 4}, '{-1, 5, -3, 2}, '{7, 0, -8, 1}};
  int mh [3][3];
  int ph [3][3];
  int mset, mch, pset, pch;
  bit parmed;

  always #2 clk = ~clk;

  mcfir uut (
    .clk(clk), .aresetn(aresetn), .aclken(aclken), .s_valid(s_valid), .s_data(s_data),
    .s_last(s_last), .cfg_valid(cfg_valid), .cfg_sel(cfg_sel), .cfg_ready(cfg_ready),
    .m_valid(m_valid), .m_data(m_data), .m_user(m_user), .m_last(m_last), .frame_err(frame_err)
  );

  mcfir #(.SYNC(mcfir_pkg::SYNC_PACKET)) uut_pkt (
    .clk(clk), .aresetn(aresetn), .aclken(aclken), .s_valid(s_valid), .s_data(s_data),
    .s_last(s_last), .cfg_valid(cfg_valid), .cfg_sel(cfg_sel), .cfg_ready(p_cfg_ready),
    .m_valid(p_valid), .m_data(p_data), .m_user(p_user), .m_last(p_last), .frame_err(p_err)
  );

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 3; c++)
      for (int k = 0; k < 3; k++) begin mh[c][k] = 0; ph[c][k] = 0; end
    mset = 0; mch = 0; pset = 0; pch = 0; parmed = 1'b0;
  endtask

  task automatic step(input int x, input bit lst, input bit cv, input int sel);
    int acc, e_data, e_user, e_last, e_err, pe_data, pe_user, pe_last;
    bit pcons;
    @(negedge clk);
    aclken = 1'b1; s_valid = 1'b1; s_data = 8'(x); s_last = lst;
    cfg_valid = cv; cfg_sel = 2'(sel);
    #1;
    chk("R4 cfg_ready vector mode", int'(cfg_ready), int'(mch == 0));
    chk("R8 cfg_ready packet mode", int'(p_cfg_ready), int'(pch == 0 && parmed));
    // vector-mode model (R1 R2 R3 R5 R6 R7)
    if (mch == 0 && cv && sel < 3) mset = sel;
    acc = C[mset][0] * x;
    for (int k = 1; k < 4; k++) acc += C[mset][k] * mh[mch][k-1];
    e_data = acc >>> 2; e_user = mch; e_last = int'(mch == 2);
    e_err = int'(lst != (mch == 2));
    mh[mch][2] = mh[mch][1]; mh[mch][1] = mh[mch][0]; mh[mch][0] = x;
    mch = (lst || mch == 2) ? 0 : mch + 1;
    // packet-mode model (R8)
    pcons = (pch == 0) && parmed && cv;
    if (pcons && sel < 3) pset = sel;
    acc = C[pset][0] * x;
    for (int k = 1; k < 4; k++) acc += C[pset][k] * ph[pch][k-1];
    pe_data = acc >>> 2; pe_user = pch; pe_last = int'(lst);
    if (lst) parmed = 1'b1; else if (pcons) parmed = 1'b0;
    ph[pch][2] = ph[pch][1]; ph[pch][1] = ph[pch][0]; ph[pch][0] = x;
    pch = (pch == 2) ? 0 : pch + 1;
    @(posedge clk); #1;
    chk("R1 m_valid", int'(m_valid), 1);
    chk("R2 R3 R5 m_data", int'($signed(m_data)), e_data);
    chk("R1 m_user", int'(m_user), e_user);
    chk("R6 m_last", int'(m_last), e_last);
    chk("R7 frame_err", int'(frame_err), e_err);
    chk("R8 packet m_data", int'($signed(p_data)), pe_data);
    chk("R8 packet m_user", int'(p_user), pe_user);
    chk("R8 packet m_last", int'(p_last), pe_last);
    chk("R8 packet frame_err", int'(p_err), 0);
  endtask

  task automatic chk_cleared(input string tag);
    chk({tag, " m_valid"},   int'(m_valid), 0);
    chk({tag, " m_data"},    int'(m_data), 0);
    chk({tag, " m_user"},    int'(m_user), 0);
    chk({tag, " m_last"},    int'(m_last), 0);
    chk({tag, " frame_err"}, int'(frame_err), 0);
    chk({tag, " packet m_valid"}, int'(p_valid), 0);
    chk({tag, " cfg_ready"}, int'(cfg_ready), 0);
  endtask

  initial begin
    int hv, hd, hu, hl;
    aresetn = 1'b0; aclken = 1'b0; s_valid = 1'b0; s_last = 1'b0;
    s_data = '0; cfg_valid = 1'b0; cfg_sel = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 chk_cleared("R11 power-up");
    @(negedge clk); aresetn = 1'b1;

    // sweep: patterns, every set, out-of-range select, mid-vector configs
    for (int v = 0; v < 16; v++)
      for (int c = 0; c < 3; c++) begin
        int x;
        if (v < 4)       x = v * 3 + c - 5;
        else if (v < 8)  x = ((v + c) % 2) ? 127 : -128;
        else             x = ((v * 37 + c * 11) % 256) - 128;
        step(x, c == 2, (v % 3) != 2 || c == 1, (v + 1) % 4);
      end

    // framing errors: early last, missing last
    step(10, 1'b1, 1'b0, 0);
    step(-20, 1'b0, 1'b0, 0);
    step(33, 1'b0, 1'b0, 0);
    step(-7, 1'b0, 1'b0, 0);
    step(50, 1'b1, 1'b1, 2);
    for (int c = 0; c < 3; c++) step(c * 40 - 60, c == 2, 1'b0, 0);

    // R9: enable low freezes everything
    hv = int'(m_valid); hd = int'(m_data); hu = int'(m_user); hl = int'(m_last);
    @(negedge clk);
    aclken = 1'b0; s_valid = 1'b1; s_data = 8'd99; s_last = 1'b1;
    cfg_valid = 1'b1; cfg_sel = 2'd1;
    #1 chk("R9 cfg_ready with enable low", int'(cfg_ready), 0);
    repeat (3) @(posedge clk);
    #1;
    chk("R9 m_valid held", int'(m_valid), hv);
    chk("R9 m_data held", int'(m_data), hd);
    chk("R9 m_user held", int'(m_user), hu);
    chk("R9 m_last held", int'(m_last), hl);
    for (int c = 0; c < 3; c++) step(c + 9, c == 2, 1'b0, 0);

    // R10: idle cycle with enable high
    @(negedge clk);
    aclken = 1'b1; s_valid = 1'b0; s_last = 1'b1; cfg_valid = 1'b1; cfg_sel = 2'd2;
    #1 chk("R10 cfg_ready while idle", int'(cfg_ready), 0);
    @(posedge clk); #1;
    chk("R10 m_valid low", int'(m_valid), 0);
    chk("R10 packet m_valid low", int'(p_valid), 0);
    for (int c = 0; c < 3; c++) step(-c - 3, c == 2, 1'b0, 0);

    // R11: reset with enable low, mid-run
    step(77, 1'b0, 1'b0, 0);
    @(negedge clk); aclken = 1'b0; s_valid = 1'b0; aresetn = 1'b0;
    repeat (2) @(posedge clk);
    #1 chk_cleared("R11 mid-run");
    @(negedge clk); aresetn = 1'b1;
    model_reset();
    for (int v = 0; v < 2; v++)
      for (int c = 0; c < 3; c++) step(c * 17 + v - 20, c == 2, 1'b0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule